// File: doc/BRIEF.md
# Iterative IDEA Block Cipher Core

This core transforms one 64-bit block with the IDEA cipher. The block is split into four 16-bit words. The core runs eight full rounds and then an output transform. Each round is worked through as a fixed sequence of steps. Every multiplication modulo 65537 in that sequence goes through a single registered multiplier. Subkeys are not stored inside the core. A 6-bit index leaves the core, and the 16-bit subkey at that index must come back on the same cycle.

The same hardware decrypts. The caller only has to present the inverted subkey schedule in place of the forward one. The caller starts a job with a start strobe and then watches busy. A one-cycle done strobe marks the moment the output register holds the result. A new job can be started in the same cycle that done is high.

Top module: `idea_iter_core`

## Requirements
- R1: While reset is held and afterwards until the first job completes, busy_o and done_o are 0 and block_o is all zeros.
- R2: A start_i sampled high while busy_o is 0 loads block_i and raises busy_o in the next cycle. busy_o then stays high for exactly 61 cycles (7 per round for 8 rounds, plus 5 for the output transform).
- R3: A start_i sampled high while busy_o is 1 is ignored. The running job's result, its timing and the number of done pulses do not change.
- R4: done_o is high for exactly one cycle, the first cycle after busy_o falls. block_o changes only in that cycle and then holds its value until the next completion.
- R5: block_o equals the IDEA transform of the loaded block under the presented subkeys. Word x1 is block[63:48] and x4 is block[15:0], and each word carries its first byte in bits 15:8. Each round computes x1*k0, x2+k1, x3+k2 and x4*k3. It then computes x3 = (x3^x1)*k4 from the saved x3, and x2 = ((x2^x4)+x3)*k5 from the saved x2. After that come the sequential updates x3 += x2, x1 ^= x2, x4 ^= x3, x2 ^= saved x3, and x3 ^= saved x2. The output is {x1*k48, x3+k49, x2+k50, x4*k51}.
- R6: In every multiplication, an operand or subkey of 0 stands for 65536, and a product equal to 65536 is returned as 0.
- R7: Round r (0..7) reads subkey indices 6r to 6r+5 in the order of R5, one index per step cycle. The output transform reads 48, 49, 50 and 51. key_idx_o never exceeds 51 while busy_o is high.
- R8: Running the core on a ciphertext with the inverted subkey schedule returns the original plaintext.
- R9: A start_i sampled high in the cycle where done_o is high is accepted, so busy_o is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a job with block_i when idle |
| block_i | input | 64 | Block to transform, x1 in the top 16 bits |
| key_val_i | input | 16 | Subkey at key_idx_o, same cycle |
| busy_o | output | 1 | A job is running |
| done_o | output | 1 | One-cycle strobe, result valid |
| block_o | output | 64 | Result register |
| key_idx_o | output | 6 | Subkey index being read |

## Verification
Two things can happen in the same cycle: a finished job raises done_o and updates block_o, and a new start is accepted. The bench holds start_i high across the end of a job. It also swaps block_i in the done cycle. It then expects busy_o to rise on the next edge, the old result to stay in block_o, and the new result to arrive 61 cycles later. A start pulse in the middle of a job is also driven. The reference model counts every cycle, so a second done pulse or a shifted completion is caught on the cycle it happens.

// File: rtl/idea_pkg.sv
package idea_pkg;
  localparam int WORD_W = 16;
  localparam int KEYS_PER_ROUND = 6;
  localparam int KEYS_FINAL = 4;

  typedef logic [WORD_W-1:0] word_t;

  // step sequence of one job; each state reads at most one subkey
  typedef enum logic [3:0] {
    ST_IDLE, ST_MA, ST_AB, ST_AC, ST_MD, ST_ME, ST_MF, ST_MIX,
    ST_O1, ST_O2, ST_O3, ST_O4, ST_O5
  } step_e;
endpackage

// File: rtl/idea_mul.sv
module idea_mul
  import idea_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en_i,
  input  word_t a_i,
  input  word_t b_i,
  output word_t p_o
);
  logic [16:0] a_ext, b_ext;
  logic [32:0] prod;
  logic [16:0] hi;
  word_t       lo;
  logic        borrow;
  word_t       p_d;

  // operand 0 means 2^16; the reduction uses 2^16 == -1 mod 65537
  always_comb begin
    a_ext  = (a_i == '0) ? 17'h10000 : {1'b0, a_i};
    b_ext  = (b_i == '0) ? 17'h10000 : {1'b0, b_i};
    prod   = {16'b0, a_ext} * {16'b0, b_ext};
    lo     = prod[15:0];
    hi     = prod[32:16];
    borrow = ({1'b0, lo} < hi);
    p_d    = lo - hi[15:0] + {15'b0, borrow};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    p_o <= '0;
    else if (en_i) p_o <= p_d;
  end
endmodule

// File: rtl/idea_seq.sv
module idea_seq
  import idea_pkg::*;
#(
  parameter int ROUNDS = 8,
  parameter int IDXW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  output step_e           step_o,
  output logic [IDXW-1:0] key_idx_o,
  output logic            busy_o
);
  localparam int RW = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;

  step_e           step_q, step_d;
  logic [RW-1:0]   rnd_q, rnd_d;
  logic [IDXW-1:0] base_q, base_d;
  logic [1:0]      off;

  always_comb begin
    step_d = step_q;
    rnd_d  = rnd_q;
    base_d = base_q;
    unique case (step_q)
      ST_IDLE: if (start_i) begin
        step_d = ST_MA;
        rnd_d  = '0;
        base_d = '0;
      end
      ST_MA:  step_d = ST_AB;
      ST_AB:  step_d = ST_AC;
      ST_AC:  step_d = ST_MD;
      ST_MD:  step_d = ST_ME;
      ST_ME:  step_d = ST_MF;
      ST_MF:  step_d = ST_MIX;
      ST_MIX: begin
        base_d = base_q + IDXW'(KEYS_PER_ROUND);
        rnd_d  = rnd_q + 1'b1;
        step_d = (rnd_q == RW'(ROUNDS - 1)) ? ST_O1 : ST_MA;
      end
      ST_O1:  step_d = ST_O2;
      ST_O2:  step_d = ST_O3;
      ST_O3:  step_d = ST_O4;
      ST_O4:  step_d = ST_O5;
      ST_O5:  step_d = ST_IDLE;
      default: step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      rnd_q  <= '0;
      base_q <= '0;
    end else begin
      step_q <= step_d;
      rnd_q  <= rnd_d;
      base_q <= base_d;
    end
  end

  // offset of the subkey inside the current group of six (or four)
  always_comb begin
    unique case (step_q)
      ST_AB, ST_O2:        off = 2'd1;
      ST_AC, ST_O3:        off = 2'd2;
      ST_MD, ST_O4, ST_O5: off = 2'd3;
      default:             off = 2'd0;
    endcase
  end

  logic [IDXW-1:0] idx_lo, idx_hi;
  always_comb begin
    idx_lo = base_q + IDXW'(off);
    idx_hi = base_q + IDXW'(4);
    unique case (step_q)
      ST_ME:   key_idx_o = idx_hi;
      ST_MF:   key_idx_o = idx_hi + 1'b1;
      default: key_idx_o = idx_lo;
    endcase
  end

  assign step_o = step_q;
  assign busy_o = (step_q != ST_IDLE);
endmodule

// File: rtl/idea_iter_core.sv
module idea_iter_core
  import idea_pkg::*;
#(
  parameter  int ROUNDS = 8,
  localparam int NKEY   = ROUNDS * KEYS_PER_ROUND + KEYS_FINAL,
  localparam int IDXW   = $clog2(NKEY)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [63:0]     block_i,
  input  logic [15:0]     key_val_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [63:0]     block_o,
  output logic [IDXW-1:0] key_idx_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  step_e step;
  idea_seq #(.ROUNDS(ROUNDS), .IDXW(IDXW)) u_seq (
    .clk(clk), .rst_n(rst_n_s), .start_i(start_i),
    .step_o(step), .key_idx_o(key_idx_o), .busy_o(busy_o)
  );

  logic  mul_en;
  word_t mul_a, mul_q;
  idea_mul u_mul (
    .clk(clk), .rst_n(rst_n_s), .en_i(mul_en),
    .a_i(mul_a), .b_i(key_val_i), .p_o(mul_q)
  );

  word_t x1_q, x2_q, x3_q, x4_q, s2_q, s3_q;
  word_t x1_d, x2_d, x3_d, x4_d, s2_d, s3_d;
  logic  x1_en, x2_en, x3_en, x4_en, s2_en, s3_en;
  logic [63:0] out_q, out_d;
  logic        out_en, done_q, done_d;
  word_t       mix;

  always_comb begin
    x1_d = x1_q; x2_d = x2_q; x3_d = x3_q; x4_d = x4_q;
    s2_d = s2_q; s3_d = s3_q;
    x1_en = 1'b0; x2_en = 1'b0; x3_en = 1'b0; x4_en = 1'b0;
    s2_en = 1'b0; s3_en = 1'b0;
    out_d = out_q; out_en = 1'b0; done_d = 1'b0;
    mul_en = 1'b0; mul_a = x1_q;
    mix = x3_q + mul_q;
    unique case (step)
      ST_IDLE: if (start_i) begin
        x1_d = block_i[63:48]; x2_d = block_i[47:32];
        x3_d = block_i[31:16]; x4_d = block_i[15:0];
        x1_en = 1'b1; x2_en = 1'b1; x3_en = 1'b1; x4_en = 1'b1;
      end
      ST_MA: begin mul_en = 1'b1; mul_a = x1_q; end
      ST_AB: begin
        x1_d = mul_q;            x1_en = 1'b1;
        x2_d = x2_q + key_val_i; x2_en = 1'b1;
      end
      ST_AC: begin x3_d = x3_q + key_val_i; x3_en = 1'b1; end
      ST_MD: begin mul_en = 1'b1; mul_a = x4_q; end
      ST_ME: begin
        x4_d = mul_q; x4_en = 1'b1;
        s3_d = x3_q;  s3_en = 1'b1;
        mul_en = 1'b1; mul_a = x3_q ^ x1_q;
      end
      ST_MF: begin
        x3_d = mul_q; x3_en = 1'b1;
        s2_d = x2_q;  s2_en = 1'b1;
        mul_en = 1'b1; mul_a = (x2_q ^ x4_q) + mul_q;
      end
      ST_MIX: begin
        x1_d = x1_q ^ mul_q; x1_en = 1'b1;
        x2_d = mul_q ^ s3_q; x2_en = 1'b1;
        x3_d = mix ^ s2_q;   x3_en = 1'b1;
        x4_d = x4_q ^ mix;   x4_en = 1'b1;
      end
      ST_O1: begin mul_en = 1'b1; mul_a = x1_q; end
      ST_O2: begin
        x1_d = mul_q;            x1_en = 1'b1;
        x3_d = x3_q + key_val_i; x3_en = 1'b1;
      end
      ST_O3: begin x2_d = x2_q + key_val_i; x2_en = 1'b1; end
      ST_O4: begin mul_en = 1'b1; mul_a = x4_q; end
      ST_O5: begin
        out_d  = {x1_q, x3_q, x2_q, mul_q};
        out_en = 1'b1;
        done_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      x1_q <= '0; x2_q <= '0; x3_q <= '0; x4_q <= '0;
      s2_q <= '0; s3_q <= '0;
      out_q <= '0; done_q <= 1'b0;
    end else begin
      if (x1_en)  x1_q  <= x1_d;
      if (x2_en)  x2_q  <= x2_d;
      if (x3_en)  x3_q  <= x3_d;
      if (x4_en)  x4_q  <= x4_d;
      if (s2_en)  s2_q  <= s2_d;
      if (s3_en)  s3_q  <= s3_d;
      if (out_en) out_q <= out_d;
      done_q <= done_d;
    end
  end

  assign block_o = out_q;
  assign done_o  = done_q;
endmodule

// File: rtl/idea_core_chk.sv
module idea_core_chk #(
  parameter int ROUNDS = 8,
  parameter int IDXW   = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic            busy_o,
  input logic            done_o,
  input logic [63:0]     block_o,
  input logic [IDXW-1:0] key_idx_o
);
  localparam int NKEY = ROUNDS * 6 + 4;

  // R2
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(block_o) |-> done_o);

  // R7
  key_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (key_idx_o < IDXW'(NKEY)));
endmodule

bind idea_iter_core idea_core_chk #(.ROUNDS(ROUNDS), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .block_o(block_o), .key_idx_o(key_idx_o)
);

// File: tb/test_idea_iter_core.sv
module test_idea_iter_core;
  localparam int LAT = 61;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] block_i = '0;
  logic [15:0] key_val_i;
  logic        busy_o, done_o;
  logic [63:0] block_o;
  logic [5:0]  key_idx_o;

  logic [15:0] keys [52];
  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  assign key_val_i = (key_idx_o < 6'd52) ? keys[key_idx_o] : 16'h0;

  idea_iter_core i_idea_iter_core (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .block_i(block_i),
    .key_val_i(key_val_i), .busy_o(busy_o), .done_o(done_o),
    .block_o(block_o), .key_idx_o(key_idx_o)
  );

  function automatic longint mm(input longint a, input longint b);
    longint aa, bb, r;
    aa = (a == 0) ? 65536 : a;
    bb = (b == 0) ? 65536 : b;
    r = (aa * bb) % 65537;
    return (r == 65536) ? 0 : r;
  endfunction

  function automatic logic [63:0] ref_cipher(input logic [63:0] b, input logic [15:0] kk [52]);
    longint x1, x2, x3, x4, t2, t3;
    x1 = b[63:48]; x2 = b[47:32]; x3 = b[31:16]; x4 = b[15:0];
    for (int r = 0; r < 8; r++) begin
      x1 = mm(x1, kk[6*r]);
      x2 = (x2 + kk[6*r+1]) % 65536;
      x3 = (x3 + kk[6*r+2]) % 65536;
      x4 = mm(x4, kk[6*r+3]);
      t3 = x3;
      x3 = mm(x3 ^ x1, kk[6*r+4]);
      t2 = x2;
      x2 = mm(((x2 ^ x4) + x3) % 65536, kk[6*r+5]);
      x3 = (x3 + x2) % 65536;
      x1 = x1 ^ x2;
      x4 = x4 ^ x3;
      x2 = x2 ^ t3;
      x3 = x3 ^ t2;
    end
    return {16'(mm(x1, kk[48])), 16'((x3 + kk[49]) % 65536),
            16'((x2 + kk[50]) % 65536), 16'(mm(x4, kk[51]))};
  endfunction

  function automatic logic [15:0] minv(input logic [15:0] a);
    longint base, res;
    base = (a == 0) ? 65536 : a;
    res = 1;
    for (int e = 0; e < 16; e++) begin
      res = (res * base) % 65537;
      base = (base * base) % 65537;
    end
    return (res == 65536) ? 16'h0 : 16'(res);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // cycle model
  logic        m_busy = 1'b0, m_done = 1'b0;
  logic [63:0] m_out = '0, m_pend = '0;
  int          m_cnt = 0;
  bit          model_on = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 1'b0; m_done = 1'b0; m_out = '0; m_cnt = 0;
    end else begin
      m_done = 1'b0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 1'b0; m_done = 1'b1; m_out = m_pend;
        end
      end else if (start_i) begin
        m_busy = 1'b1; m_cnt = LAT; m_pend = ref_cipher(block_i, keys);
      end
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      chk("R2 busy", {63'b0, busy_o}, {63'b0, m_busy});
      chk("R4 done", {63'b0, done_o}, {63'b0, m_done});
      chk("R5 block", block_o, m_out);
      if (m_busy) begin
        automatic int c = LAT - m_cnt;
        if (c < 56 && (c % 7) < 6)
          chk("R7 index", {58'b0, key_idx_o}, 64'((c / 7) * 6 + (c % 7)));
        else if (c >= 56 && c < 60)
          chk("R7 index", {58'b0, key_idx_o}, 64'(48 + c - 56));
      end
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run(input logic [63:0] b);
    @(negedge clk);
    block_i = b; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
  endtask

  task automatic fill_keys(input int seed);
    int s = seed;
    for (int i = 0; i < 52; i++) begin
      s = s * 1103515245 + 12345;
      keys[i] = s[30:15];
    end
  endtask

  initial begin
    logic [63:0] ct, pt;
    logic [15:0] ek [52];
    fill_keys(7);
    repeat (3) @(negedge clk);
    // R1: held in reset
    chk("R1 reset", {busy_o, done_o, block_o}, 66'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after reset", {busy_o, done_o, block_o}, 66'b0);
    model_on = 1'b1;

    // R5 R7: distinct keys, several block patterns
    run(64'h0000_0001_0002_0003);
    chk("R5 pattern1", block_o, ref_cipher(64'h0000_0001_0002_0003, keys));
    run(64'hFFFF_FFFF_FFFF_FFFF);
    chk("R5 ones", block_o, ref_cipher(64'hFFFF_FFFF_FFFF_FFFF, keys));
    run(64'h0123_4567_89AB_CDEF);
    chk("R5 ramp", block_o, ref_cipher(64'h0123_4567_89AB_CDEF, keys));

    // R6: zero subkeys and zero data words
    for (int i = 0; i < 52; i += 3) keys[i] = 16'h0;
    keys[51] = 16'h0;
    run(64'h0);
    chk("R6 zero block", block_o, ref_cipher(64'h0, keys));
    run(64'h0000_8000_0000_0001);
    chk("R6 mixed zero", block_o, ref_cipher(64'h0000_8000_0000_0001, keys));

    // R3: start pulse mid-job with another block
    fill_keys(99);
    @(negedge clk);
    block_i = 64'hDEAD_BEEF_0BAD_F00D; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (10) @(negedge clk);
    block_i = 64'h1111_2222_3333_4444; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    chk("R3 ignored start", block_o, ref_cipher(64'hDEAD_BEEF_0BAD_F00D, keys));
    @(negedge clk);
    chk("R3 idle after", {62'b0, busy_o, done_o}, 64'b0);

    // R9: start held through the done cycle
    block_i = 64'hA5A5_5A5A_C3C3_3C3C; start_i = 1'b1;
    @(negedge clk);
    while (!done_o) @(negedge clk);
    block_i = 64'h0F0F_F0F0_1234_8765;
    @(negedge clk);
    start_i = 1'b0;
    chk("R9 accepted on done", {63'b0, busy_o}, 64'b1);
    chk("R9 old result kept", block_o, ref_cipher(64'hA5A5_5A5A_C3C3_3C3C, keys));
    while (!done_o) @(negedge clk);
    chk("R9 second result", block_o, ref_cipher(64'h0F0F_F0F0_1234_8765, keys));

    // R8: decrypt with the inverted schedule
    pt = 64'h0102_0304_0506_0708;
    run(pt);
    ct = block_o;
    for (int i = 0; i < 52; i++) ek[i] = keys[i];
    for (int r = 0; r < 9; r++) begin
      automatic int e = 48 - 6 * r;
      keys[6*r]   = minv(ek[e]);
      keys[6*r+1] = (r == 0 || r == 8) ? 16'(-ek[e+1]) : 16'(-ek[e+2]);
      keys[6*r+2] = (r == 0 || r == 8) ? 16'(-ek[e+2]) : 16'(-ek[e+1]);
      keys[6*r+3] = minv(ek[e+3]);
      if (r < 8) begin
        keys[6*r+4] = ek[e-2];
        keys[6*r+5] = ek[e-1];
      end
    end
    run(ct);
    chk("R8 decrypt", block_o, pt);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule